// File: doc/BRIEF.md
# Dual-Set Phase-Coherent Hopping NCO Channel

This block is the phase generator of one numerically controlled oscillator channel in a digital down-converter. It holds two tuning sets. Each set has a 48-bit frequency control word and a 19-bit phase offset, and each set has its own 48-bit phase accumulator. Both accumulators integrate their own control words on every clock, whichever set is selected. A hop from one set to the other therefore lands on the phase that set would have had if no hop had occurred.

Software does not write the live tuning values directly. It writes a staging copy of each set, and an update strobe copies the staged values into the active registers. The accumulators have a synchronous clear strobe. The clear and the update each have their own mask input, so the channel can be left out of a shared clear or a shared update. The hop select comes either from a dedicated pin or from a software bit, chosen by a source bit. The output is a registered 19-bit phase word for the selected set. The sine/cosine lookup, the mixer and the filtering are outside this block.

Top module: `nco_dual_hop`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulators, the staged values, the active values and `phase_out` all become zero.
- R2: On each edge without an unmasked clear, every accumulator adds its set's active control word, wrapping modulo 2^48.
- R3: `phase_out` equals accumulator bits [47:29] of the selected set plus that set's active phase offset, modulo 2^19. It is registered one clock after the accumulator and select values it is computed from.
- R4: Both accumulators advance on every clock whichever set is selected, so the output after a hop matches the phase of the newly chosen set as if it had never been deselected.
- R5: With `hop_src`=0 the selected set index is `hop_pin`. With `hop_src`=1 it is `hop_sw` (0 picks set 0, 1 picks set 1).
- R6: `hop_mode` has no effect on the output. Both values give phase-coherent behaviour.
- R7: A write with `stg_we` changes only the staged values of set `stg_idx`. An update strobe (`upd_req`=1, `upd_mask`=0) copies both sets' staged values into the active registers at that edge, so they take effect on the accumulator one edge later.
- R8: When `upd_mask`=1, `upd_req` is ignored and the active values are unchanged.
- R9: An unmasked clear (`clr_req`=1, `clr_mask`=0) sets both accumulators to zero at that edge. When `clr_mask`=1, `clr_req` is ignored.
- R10: An unmasked clear and an unmasked update in the same cycle zero the accumulators and load the new words. The next edge then leaves each accumulator equal to its new control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hop_src | input | 1 | Hop select source: 0 pin, 1 software bit |
| hop_mode | input | 1 | Hop mode; both values phase coherent |
| hop_pin | input | 1 | Hop select from the dedicated pin |
| hop_sw | input | 1 | Hop select from software |
| stg_we | input | 1 | Write strobe for the staged set |
| stg_idx | input | 1 | Set index for the staged write |
| stg_fcw | input | 48 | Staged frequency control word |
| stg_ph | input | 19 | Staged phase offset |
| clr_req | input | 1 | Accumulator clear strobe |
| clr_mask | input | 1 | 1 ignores the clear strobe |
| upd_req | input | 1 | Staged-to-active update strobe |
| upd_mask | input | 1 | 1 ignores the update strobe |
| phase_out | output | 19 | Registered phase word of the selected set |

## Verification
The clear and the update can fall on the same edge. This is the case where the order of the two actions decides whether the restarted accumulator uses the old or the new word. The bench writes a new staged word and raises both strobes together. It then checks the output on the two following clocks against values worked out by hand: the new offset alone, then the new offset plus one step of the new word. It also raises a masked update together with an unmasked clear and checks that the accumulator restarts from zero with the old word and the old offset.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int NCO_FCW_W = 48;
  localparam int NCO_PH_W  = 19;
  localparam int NCO_SETS  = 2;
endpackage

// File: rtl/nco_set_regs.sv
module nco_set_regs #(
  parameter int FCW_W = nco_pkg::NCO_FCW_W,
  parameter int PH_W  = nco_pkg::NCO_PH_W,
  parameter int SETS  = nco_pkg::NCO_SETS,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [FCW_W-1:0]           wr_fcw,
  input  logic [PH_W-1:0]            wr_ph,
  input  logic                       upd_go,
  output logic [SETS-1:0][FCW_W-1:0] act_fcw,
  output logic [SETS-1:0][PH_W-1:0]  act_ph
);
  logic [SETS-1:0][FCW_W-1:0] stg_fcw_q;
  logic [SETS-1:0][PH_W-1:0]  stg_ph_q;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (rst) begin
        stg_fcw_q[s] <= '0;
        stg_ph_q[s]  <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(s))) begin
        stg_fcw_q[s] <= wr_fcw;
        stg_ph_q[s]  <= wr_ph;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        act_fcw[s] <= '0;
        act_ph[s]  <= '0;
      end else if (upd_go) begin
        act_fcw[s] <= stg_fcw_q[s];
        act_ph[s]  <= stg_ph_q[s];
      end
    end

    // R7: an update moves the staged set into the active set
    p_load_r7: assert property (@(posedge clk) disable iff (rst)
      upd_go |=> (act_fcw[s] == $past(stg_fcw_q[s])) && (act_ph[s] == $past(stg_ph_q[s])));

    // R8: without an update the active set holds
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !upd_go |=> $stable(act_fcw[s]) && $stable(act_ph[s]));
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int FCW_W = nco_pkg::NCO_FCW_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_go,
  input  logic [FCW_W-1:0] fcw,
  output logic [FCW_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst || clr_go) acc <= '0;
    else               acc <= acc + fcw;
  end

  // R9: a clear zeroes the accumulator on the next edge
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clr_go |=> (acc == '0));

  // R2: otherwise it steps by the active word, wrapping
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    !clr_go |=> (acc == FCW_W'($past(acc) + $past(fcw))));
endmodule

// File: rtl/nco_phase_out.sv
module nco_phase_out #(
  parameter int FCW_W = nco_pkg::NCO_FCW_W,
  parameter int PH_W  = nco_pkg::NCO_PH_W,
  parameter int SETS  = nco_pkg::NCO_SETS,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [IDX_W-1:0]           sel,
  input  logic [SETS-1:0][FCW_W-1:0] acc,
  input  logic [SETS-1:0][PH_W-1:0]  ph,
  output logic [PH_W-1:0]            phase_out
);
  logic [SETS-1:0][PH_W-1:0] cand;

  for (genvar s = 0; s < SETS; s++) begin : g_cand
    assign cand[s] = acc[s][FCW_W-1 -: PH_W] + ph[s];
  end

  always_ff @(posedge clk) begin
    if (rst) phase_out <= '0;
    else     phase_out <= cand[sel];
  end
endmodule

// File: rtl/nco_dual_hop.sv
module nco_dual_hop #(
  parameter int FCW_W = nco_pkg::NCO_FCW_W,
  parameter int PH_W  = nco_pkg::NCO_PH_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hop_src,
  input  logic             hop_mode,
  input  logic             hop_pin,
  input  logic             hop_sw,
  input  logic             stg_we,
  input  logic             stg_idx,
  input  logic [FCW_W-1:0] stg_fcw,
  input  logic [PH_W-1:0]  stg_ph,
  input  logic             clr_req,
  input  logic             clr_mask,
  input  logic             upd_req,
  input  logic             upd_mask,
  output logic [PH_W-1:0]  phase_out
);
  localparam int SETS = 2;

  logic                       clr_go, upd_go, hop_sel;
  logic [SETS-1:0][FCW_W-1:0] act_fcw;
  logic [SETS-1:0][PH_W-1:0]  act_ph;
  logic [SETS-1:0][FCW_W-1:0] acc;
  logic                       unused_mode;

  assign clr_go      = clr_req & ~clr_mask;
  assign upd_go      = upd_req & ~upd_mask;
  assign hop_sel     = hop_src ? hop_sw : hop_pin;
  assign unused_mode = hop_mode;

  nco_set_regs #(.FCW_W(FCW_W), .PH_W(PH_W), .SETS(SETS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(stg_we), .wr_idx(stg_idx),
    .wr_fcw(stg_fcw), .wr_ph(stg_ph), .upd_go(upd_go),
    .act_fcw(act_fcw), .act_ph(act_ph)
  );

  for (genvar s = 0; s < SETS; s++) begin : g_acc
    nco_phase_acc #(.FCW_W(FCW_W)) u_acc (
      .clk(clk), .rst(rst), .clr_go(clr_go), .fcw(act_fcw[s]), .acc(acc[s])
    );

    // R10: clear with update restarts from zero using the new word
    p_clr_upd_r10: assert property (@(posedge clk) disable iff (rst)
      (clr_go && upd_go) ##1 !clr_go |=> (acc[s] == act_fcw[s]));
  end

  nco_phase_out #(.FCW_W(FCW_W), .PH_W(PH_W), .SETS(SETS)) u_out (
    .clk(clk), .rst(rst), .sel(hop_sel), .acc(acc), .ph(act_ph),
    .phase_out(phase_out)
  );

  // R3 / R5: output tracks the chosen set's accumulator and offset, one clock late
  p_out_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase_out == PH_W'($past(hop_src ? acc[hop_sw][FCW_W-1 -: PH_W] + act_ph[hop_sw]
                                                : acc[hop_pin][FCW_W-1 -: PH_W] + act_ph[hop_pin]))));
endmodule

// File: tb/nco_dual_hop_tb.sv
module nco_dual_hop_tb;
  localparam int CLK_P = 10;
  localparam int FW = 48;
  localparam int PW = 19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hop_src = 0, hop_mode = 0, hop_pin = 0, hop_sw = 0;
  logic stg_we = 0, stg_idx = 0;
  logic [FW-1:0] stg_fcw = '0;
  logic [PW-1:0] stg_ph = '0;
  logic clr_req = 0, clr_mask = 0, upd_req = 0, upd_mask = 0;
  logic [PW-1:0] phase_out;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  nco_dual_hop u_dut (
    .clk(clk), .rst(rst), .hop_src(hop_src), .hop_mode(hop_mode),
    .hop_pin(hop_pin), .hop_sw(hop_sw), .stg_we(stg_we), .stg_idx(stg_idx),
    .stg_fcw(stg_fcw), .stg_ph(stg_ph), .clr_req(clr_req), .clr_mask(clr_mask),
    .upd_req(upd_req), .upd_mask(upd_mask), .phase_out(phase_out)
  );

  // Reference model built from the requirements; candidates for both sets
  logic [FW-1:0] m_acc [2];
  logic [FW-1:0] m_fcw [2];
  logic [PW-1:0] m_ph  [2];
  logic [FW-1:0] m_sf  [2];
  logic [PW-1:0] m_sp  [2];
  logic [PW-1:0] m_cand[2];

  always @(posedge clk) begin
    for (int s = 0; s < 2; s++) begin
      if (rst) begin
        m_acc[s] <= '0; m_fcw[s] <= '0; m_ph[s] <= '0;
        m_sf[s] <= '0; m_sp[s] <= '0; m_cand[s] <= '0;
      end else begin
        m_cand[s] <= m_acc[s][FW-1 -: PW] + m_ph[s];
        m_acc[s]  <= (clr_req && !clr_mask) ? '0 : m_acc[s] + m_fcw[s];
        if (upd_req && !upd_mask) begin
          m_fcw[s] <= m_sf[s];
          m_ph[s]  <= m_sp[s];
        end
        if (stg_we && (stg_idx == s[0])) begin
          m_sf[s] <= stg_fcw;
          m_sp[s] <= stg_ph;
        end
      end
    end
  end

  // {hop_src, hop_pin, hop_sw, hop_mode, expected set, run length[2:0]}
  localparam logic [7:0] VEC [8] = '{
    8'b0_0_1_1_0_011, 8'b0_1_0_1_1_010, 8'b1_1_0_0_0_011, 8'b1_0_1_0_1_100,
    8'b0_0_1_0_0_010, 8'b1_0_1_1_1_001, 8'b0_1_1_0_1_010, 8'b1_1_0_1_0_011
  };

  task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: phase_out=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1 reset state", phase_out, 19'd0);
    rst = 1'b0;

    // stage both sets; nothing reaches the output yet
    stg_we = 1; stg_idx = 0; stg_fcw = 48'd3 << 29; stg_ph = 19'd7; tick();
    stg_idx = 1; stg_fcw = 48'd5 << 29; stg_ph = 19'd100; tick();
    stg_we = 0; tick(); tick();
    chk("R7 staged write not yet active", phase_out, 19'd0);

    upd_req = 1; tick(); upd_req = 0;
    chk("R7 output before new values used", phase_out, 19'd0);
    tick();
    chk("R7 new offset one clock after strobe", phase_out, 19'd7);

    // table walk: hop source, pin, software bit, mode
    for (int v = 0; v < 8; v++) begin
      hop_src  = VEC[v][7];
      hop_pin  = VEC[v][6];
      hop_sw   = VEC[v][5];
      hop_mode = VEC[v][4];
      for (int c = 0; c < int'(VEC[v][2:0]); c++) begin
        tick();
        chk("R4/R5/R6 hop table", phase_out, m_cand[VEC[v][3]]);
      end
    end

    // R10: clear and update together
    hop_src = 0; hop_pin = 0;
    stg_we = 1; stg_idx = 0; stg_fcw = 48'd2 << 29; stg_ph = 19'd1; tick();
    stg_we = 0; clr_req = 1; upd_req = 1; tick();
    clr_req = 0; upd_req = 0; tick();
    chk("R10 restart from zero with new offset", phase_out, 19'd1);
    tick();
    chk("R10 one step of new word", phase_out, 19'd3);
    hop_pin = 1; tick();
    chk("R4 hop to set 1 stays coherent", phase_out, 19'd110);

    // R8: masked update with unmasked clear
    hop_pin = 0;
    stg_we = 1; stg_idx = 0; stg_fcw = 48'd9 << 29; stg_ph = 19'd50; tick();
    stg_we = 0; upd_req = 1; upd_mask = 1; clr_req = 1; tick();
    upd_req = 0; upd_mask = 0; clr_req = 0; tick();
    chk("R8 masked update keeps old offset", phase_out, 19'd1);
    tick();
    chk("R8 masked update keeps old word", phase_out, 19'd3);

    // R9: masked clear is ignored
    clr_req = 1; clr_mask = 1; tick();
    clr_req = 0; clr_mask = 0;
    chk("R9 masked clear pre", phase_out, 19'd5);
    tick();
    chk("R9 masked clear ignored", phase_out, 19'd7);

    // R9: unmasked clear zeroes both accumulators
    clr_req = 1; tick(); clr_req = 0;
    chk("R9 before clear lands", phase_out, 19'd9);
    tick();
    chk("R9 set 0 cleared", phase_out, 19'd1);
    hop_pin = 1; tick();
    chk("R9 set 1 cleared too", phase_out, 19'd105);

    // R1: reset in mid-run
    rst = 1; tick(); rst = 0;
    chk("R1 reset clears output", phase_out, 19'd0);
    tick();
    chk("R1 reset clears active offset", phase_out, 19'd0);
    tick();
    chk("R2 active word cleared, no stepping", phase_out, 19'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule